// File: doc/BRIEF.md
# Zero-Address Stack Evaluator

This block evaluates arithmetic expressions written as a stream of zero-address commands. Each command names an operation only. Operands come implicitly from the top of an internal last-in-first-out store, so no register or memory fields appear in a command. A push takes a value from the command's data field and places it on top. A pop removes the top value and presents it on a result port. Add, subtract, multiply and divide consume the two topmost entries and leave one result. Negate rewrites the top entry in place.

Commands arrive over a valid/ready handshake. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The source must hold `cmd_op` and `cmd_data` steady while `cmd_valid` is high and `cmd_ready` is low. Add, subtract, negate, push, pop and no-op finish at the edge that accepts them. Multiply and divide run bit-serially and hold `cmd_ready` low until their result is written back. The popped value is a one-cycle pulse with no back-pressure. The top entry, the current depth and three error flags are plain status outputs.

An expression such as C + D×E is evaluated by pushing C, D and E, then issuing multiply and then add. For subtract and divide, the entry just below the top is the left operand and the top entry is the right operand.

Top module: `stack_eval`

## Requirements
- R1: A push (op code 0) accepted while depth < DEPTH writes `cmd_data` to the top; in the next cycle `depth` is one higher and `tos` equals that data.
- R2: A pop (op code 1) accepted with depth ≥ 1 lowers depth by one. In the cycle after acceptance, `pop_valid` is high for exactly one cycle and `pop_data` carries the value that was on top. With an empty stack, `tos` reads 0.
- R3: Add (op code 2) and subtract (op code 3) replace the two topmost entries with (second + top) or (second − top), wrapped to W bits, and lower depth by one.
- R4: Multiply (op code 4) replaces the two topmost entries with the low W bits of their product and lowers depth by one.
- R5: Divide (op code 5) with a non-zero top replaces the two topmost entries with second ÷ top, signed and truncated toward zero, wrapped to W bits, and lowers depth by one.
- R6: Divide with a zero top raises `err_divzero`, pushes 0 in place of the two operands and lowers depth by one.
- R7: Negate (op code 6) replaces the top entry with its two's complement negation and leaves depth unchanged.
- R8: A push accepted while depth = DEPTH raises `err_overflow` and leaves depth and contents unchanged.
- R9: A command that needs more entries than are present raises `err_underflow`. Binary commands need two entries; pop and negate need one. Such a command leaves the stack unchanged and produces no `pop_valid`.
- R10: `cmd_ready` is low from the cycle after a multiply or divide is accepted until its result is written. A command held on `cmd_valid` during that time takes effect exactly once.
- R11: The three error flags describe the most recently accepted command. A no-op (op code 7) leaves the stack unchanged and clears all three flags.
- R12: After reset, depth is 0, `tos` is 0, all error flags and `pop_valid` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_data | input | W | Value for a push |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` holds a popped value |
| pop_data | output | W | Value removed by the last pop |
| tos | output | W | Current top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of entries held |
| err_overflow | output | 1 | Last command was a push into a full stack |
| err_underflow | output | 1 | Last command found too few entries |
| err_divzero | output | 1 | Last command divided by zero |

## Verification
The hardest situation to reach from the ports is a command that arrives while a multiply or divide is still iterating. It must stall and then take effect exactly once. Directed sequences hold a push on `cmd_valid` straight after the multiply is accepted, confirm that `cmd_ready` drops, and check depth and top once the push lands. Overflow needs eight stored values followed by another push, and the divide corners need particular signs and a zero divisor. Directed cases set these up explicitly, while seeded random traffic biased toward pushes drives the stack through full and empty many times.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NOP  = 3'd7
  } stk_op_e;

  // Store actions: FOLD writes the second entry and drops the top.
  typedef enum logic [2:0] {
    SA_HOLD = 3'd0,
    SA_PUSH = 3'd1,
    SA_POP  = 3'd2,
    SA_FOLD = 3'd3,
    SA_REPL = 3'd4
  } st_act_e;
endpackage

// File: rtl/stk_store.sv
module stk_store
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_act_e       act,
  input  logic [W-1:0]  wdata,
  output logic [CW-1:0] count,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos
);
  logic [W-1:0]     mem [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] we;

  // One write enable per slot, chosen by action and current fill level.
  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we[i] = ((act == SA_PUSH) && (cnt_q == CW'(i)))     ||
                   ((act == SA_REPL) && (cnt_q == CW'(i + 1))) ||
                   ((act == SA_FOLD) && (cnt_q == CW'(i + 2)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we[i]) mem[i] <= wdata;
      end
      case (act)
        SA_PUSH:         cnt_q <= cnt_q + 1'b1;
        SA_POP, SA_FOLD: cnt_q <= cnt_q - 1'b1;
        default:         cnt_q <= cnt_q;
      endcase
    end
  end

  always_comb begin
    tos = '0;
    nos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) tos = mem[i];
      if (cnt_q == CW'(i + 2)) nos = mem[i];
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/stk_muldiv.sv
module stk_muldiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int NW = $clog2(W + 1);

  logic          busy_q, div_q, neg_q;
  logic [NW-1:0] cnt_q;
  logic [W-1:0]  acc_q, mc_q, mp_q;
  logic [W:0]    rem_q;
  logic [W:0]    rsh;
  logic [W-1:0]  a_mag, b_mag;

  assign a_mag = a[W-1] ? (~a + 1'b1) : a;
  assign b_mag = b[W-1] ? (~b + 1'b1) : b;
  assign rsh   = {rem_q[W-1:0], mc_q[W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; div_q <= 1'b0; neg_q <= 1'b0; cnt_q <= '0;
      acc_q <= '0; mc_q <= '0; mp_q <= '0; rem_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      div_q  <= is_div;
      cnt_q  <= '0;
      acc_q  <= '0;
      rem_q  <= '0;
      neg_q  <= a[W-1] ^ b[W-1];
      mc_q   <= is_div ? a_mag : b;
      mp_q   <= is_div ? b_mag : a;
    end else if (busy_q) begin
      if (cnt_q == NW'(W)) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (div_q) begin
          // Restoring step: quotient bits shift in where dividend bits leave.
          if (rsh >= {1'b0, mp_q}) begin
            rem_q <= rsh - {1'b0, mp_q};
            mc_q  <= {mc_q[W-2:0], 1'b1};
          end else begin
            rem_q <= rsh;
            mc_q  <= {mc_q[W-2:0], 1'b0};
          end
        end else begin
          if (mc_q[0]) acc_q <= acc_q + mp_q;
          mp_q <= {mp_q[W-2:0], 1'b0};
          mc_q <= {1'b0, mc_q[W-1:1]};
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = busy_q && (cnt_q == NW'(W));
  assign result = div_q ? (neg_q ? (~mc_q + 1'b1) : mc_q) : acc_q;
endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic          pop_valid,
  output logic [W-1:0]  pop_data,
  output logic [W-1:0]  tos,
  output logic [CW-1:0] depth,
  output logic          err_overflow,
  output logic          err_underflow,
  output logic          err_divzero
);
  stk_op_e       op;
  st_act_e       act;
  logic [W-1:0]  wdata, nos, top, md_res;
  logic [CW-1:0] count;
  logic [1:0]    need;
  logic          accept, short, full, dz, md_start, md_busy, md_done;

  assign op     = stk_op_e'(cmd_op);
  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: need = 2'd2;
      OP_POP, OP_NEG:                 need = 2'd1;
      default:                        need = 2'd0;
    endcase
  end

  assign short = count < CW'(need);
  assign full  = (op == OP_PUSH) && (count == CW'(DEPTH));
  assign dz    = (op == OP_DIV) && !short && (top == '0);

  always_comb begin
    act      = SA_HOLD;
    wdata    = '0;
    md_start = 1'b0;
    if (md_done) begin
      act   = SA_FOLD;
      wdata = md_res;
    end else if (accept && !short && !full) begin
      case (op)
        OP_PUSH: begin act = SA_PUSH; wdata = cmd_data;   end
        OP_POP:  act = SA_POP;
        OP_ADD:  begin act = SA_FOLD; wdata = nos + top;  end
        OP_SUB:  begin act = SA_FOLD; wdata = nos - top;  end
        OP_NEG:  begin act = SA_REPL; wdata = ~top + 1'b1; end
        OP_MUL:  md_start = 1'b1;
        OP_DIV:  begin
          if (dz) act = SA_FOLD;
          else    md_start = 1'b1;
        end
        default: act = SA_HOLD;
      endcase
    end
  end

  stk_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .act(act), .wdata(wdata),
    .count(count), .tos(top), .nos(nos)
  );

  stk_muldiv #(.W(W)) u_md (
    .clk(clk), .rst_n(rst_n), .start(md_start), .is_div(op == OP_DIV),
    .a(nos), .b(top), .busy(md_busy), .done(md_done), .result(md_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      err_divzero   <= 1'b0;
      pop_valid     <= 1'b0;
      pop_data      <= '0;
    end else begin
      pop_valid <= accept && (op == OP_POP) && !short;
      if (accept && (op == OP_POP)) pop_data <= top;
      if (accept) begin
        err_overflow  <= full;
        err_underflow <= short;
        err_divzero   <= dz;
      end
    end
  end

  assign cmd_ready = !md_busy;
  assign tos       = top;
  assign depth     = count;
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [W-1:0]  cmd_data,
  input logic          pop_valid,
  input logic [W-1:0]  pop_data,
  input logic [W-1:0]  tos,
  input logic [CW-1:0] depth,
  input logic          err_overflow,
  input logic          err_underflow
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd0 && depth < CW'(DEPTH) |=>
      depth == $past(depth) + 1'b1 && tos == $past(cmd_data));

  // R8
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd0 && depth == CW'(DEPTH) |=> err_overflow && $stable(depth));

  // R2
  pop_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd1 && depth != '0 |=> pop_valid && pop_data == $past(tos));

  // R9
  short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op >= 3'd2 && cmd_op <= 3'd5 && depth < CW'(2) |=>
      err_underflow && $stable(depth) && !pop_valid);

  // R7
  neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd6 && depth != '0 |=> tos == (~$past(tos) + 1'b1) && $stable(depth));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'd4 || cmd_op == 3'd5) && depth >= CW'(2) && tos != '0 |=> !cmd_ready);

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> depth == $past(depth) || cmd_ready);
endmodule

bind stack_eval stack_eval_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .pop_valid(pop_valid), .pop_data(pop_data),
  .tos(tos), .depth(depth), .err_overflow(err_overflow), .err_underflow(err_underflow)
);

// File: tb/tb_stack_eval.sv
module tb_stack_eval;
  localparam int DEPTH = 8;
  localparam int W     = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = 3'd7;
  logic [W-1:0] cmd_data = '0;
  logic pop_valid;
  logic [W-1:0] pop_data, tos;
  logic [CW-1:0] depth;
  logic err_overflow, err_underflow, err_divzero;

  always #10 clk = ~clk;

  stack_eval #(.DEPTH(DEPTH), .W(W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m [DEPTH];
  int mcnt = 0;
  logic [2:0] e_flags;
  logic e_pv;
  logic [W-1:0] e_pd;
  string e_tag;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [W-1:0] m_top();
    return (mcnt == 0) ? '0 : m[mcnt-1];
  endfunction

  // Expected behaviour of one accepted command, computed from the requirements.
  task automatic apply_model(input logic [2:0] op, input logic [W-1:0] d);
    int need;
    logic signed [W-1:0] l, r;
    logic [W-1:0] res;
    need = (op >= 3'd2 && op <= 3'd5) ? 2 : ((op == 3'd1 || op == 3'd6) ? 1 : 0);
    e_flags = 3'b000; e_pv = 1'b0; e_pd = '0;
    case (op)
      3'd0: e_tag = "R1"; 3'd1: e_tag = "R2"; 3'd2, 3'd3: e_tag = "R3";
      3'd4: e_tag = "R4"; 3'd5: e_tag = "R5"; 3'd6: e_tag = "R7";
      default: e_tag = "R11";
    endcase
    if (op == 3'd0 && mcnt == DEPTH) begin
      e_flags = 3'b100; e_tag = "R8";
    end else if (mcnt < need) begin
      e_flags = 3'b010; e_tag = "R9";
    end else begin
      l = (mcnt >= 2) ? m[mcnt-2] : '0;
      r = m_top();
      case (op)
        3'd0: begin m[mcnt] = d; mcnt++; end
        3'd1: begin e_pv = 1'b1; e_pd = r; mcnt--; end
        3'd6: m[mcnt-1] = -r;
        3'd7: ;
        default: begin
          case (op)
            3'd2: res = l + r;
            3'd3: res = l - r;
            3'd4: res = W'(int'(l) * int'(r));
            default: begin
              if (r == 0) begin res = '0; e_flags = 3'b001; e_tag = "R6"; end
              else res = W'(int'(l) / int'(r));
            end
          endcase
          m[mcnt-2] = res; mcnt--;
        end
      endcase
    end
  endtask

  // Drive one command, hold it until taken, wait for completion, then compare.
  task automatic issue(input logic [2:0] op, input logic [W-1:0] d);
    logic pv; logic [W-1:0] pd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
    pv = pop_valid; pd = pop_data;
    while (!cmd_ready) @(negedge clk);
    apply_model(op, d);
    check(e_tag, "depth", depth, mcnt);
    check(e_tag, "tos", tos, m_top());
    check(e_tag, "flags", {err_overflow, err_underflow, err_divzero}, e_flags);
    check(e_tag, "pop_valid", pv, e_pv);
    if (e_pv) check(e_tag, "pop_data", pd, e_pd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "depth", depth, 0);
    check("R12", "tos", tos, 0);
    check("R12", "flags", {err_overflow, err_underflow, err_divzero}, 0);
    check("R12", "pop_valid", pop_valid, 0);
    check("R12", "ready", cmd_ready, 1);

    // R9 empty-stack underflow, R2 empty tos
    issue(3'd1, '0);
    issue(3'd2, '0);
    issue(3'd6, '0);
    // R11 no-op clears flags
    issue(3'd7, '0);

    // Expression (A-B)/(C+D*E): A=50 B=8 C=1 D=2 E=3 -> 42/7 = 6
    issue(3'd0, 16'd50); issue(3'd0, 16'd8); issue(3'd3, '0);
    check("R3", "A-B", tos, 42);
    issue(3'd0, 16'd1); issue(3'd0, 16'd2); issue(3'd0, 16'd3);
    issue(3'd4, '0); issue(3'd2, '0);
    check("R4", "C+D*E", tos, 7);
    issue(3'd5, '0);
    check("R5", "quotient", tos, 6);
    issue(3'd1, '0);

    // R5 signed truncation corners
    issue(3'hF & 3'd0, -16'sd7); issue(3'd0, 16'd2); issue(3'd5, '0);
    check("R5", "-7/2", tos, 16'hFFFD);
    issue(3'd0, 16'h8000); issue(3'd0, 16'hFFFF); issue(3'd5, '0);
    check("R5", "min/-1", tos, 16'h8000);
    // R6 divide by zero
    issue(3'd0, 16'd9); issue(3'd0, 16'd0); issue(3'd5, '0);
    check("R6", "dz flag", err_divzero, 1);
    issue(3'd7, '0);
    check("R11", "dz cleared", err_divzero, 0);
    // R4 wrap of product
    issue(3'd0, 16'h0100); issue(3'd0, 16'h0101); issue(3'd4, '0);
    check("R4", "low half", tos, 16'h0100);

    // R8 fill then overflow
    while (mcnt < DEPTH) issue(3'd0, 16'(mcnt + 100));
    issue(3'd0, 16'h7777);
    check("R8", "ovf flag", err_overflow, 1);
    while (mcnt > 2) issue(3'd1, '0);

    // R10 command held during multiply takes effect once
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    apply_model(3'd4, '0);
    cmd_op = 3'd0; cmd_data = 16'd99;
    check("R10", "ready low in multiply", cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
    apply_model(3'd0, 16'd99);
    repeat (2) @(negedge clk);
    check("R10", "held push once depth", depth, mcnt);
    check("R10", "held push tos", tos, 99);

    // Seeded random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [W-1:0] d;
      int sel;
      sel = int'($urandom % 16);
      op = (sel < 6) ? 3'd0 : 3'(sel % 8);
      d = ($urandom % 8 == 0) ? '0 : W'($urandom);
      if (op == 3'd0 && ($urandom % 4 == 0)) d = W'($urandom % 5);
      issue(op, d);
    end
    summary();
  end
endmodule